// File: doc/BRIEF.md
# Master-Mode Serial Audio Port

This block is the transmit side of a stereo serial audio port that owns its clocks. From one fast input clock it divides down a bit clock and a left/right frame clock. The frame clock's rate is selected as a fixed fraction of the master clock. On the single data line it sends one left and one right sample per frame, most significant bit first. The slot layout inside each half-frame follows one of three framings: left-justified, I²S or right-justified. The output word length is 24, 20, 18 or 16 bits, and shorter words are cut from the top of the 24-bit sample with no rounding.

The block's clock `clk` runs at four times the master-clock rate. With that clock every supported ratio gives a bit clock whose half period is a whole number of cycles, including the ratios that are not powers of two. The bit clock always runs at 64 times the frame rate, which gives 32 bit slots per channel.

An upstream producer presents a sample pair with `sampleValid`. At each frame start the block takes the pair if it is valid, signals the take with `sampleTake`, and otherwise sends the previous pair again. The ratio, framing and resolution inputs are also sampled only at frame starts.

Top module: `audio_serial_master`

## Requirements
- R1: Ratio code 0000..1000 selects master-clock/frame-clock ratios 64, 96, 128, 192, 256, 384, 512, 768, 1024 in that order, and codes 1001..1111 act as 1024. The bit clock half period is ratio/32 `clk` cycles. Each frame holds exactly 64 bit-clock periods, 32 in each frame-clock level, for a frame length of 4×ratio `clk` cycles.
- R2: `frameClk` and `serialOut` change only together with a falling edge of `bitClk`, never while `bitClk` is high. A receiver samples on the rising edge.
- R3: Framing code 000 (left-justified) drives `frameClk` high for the left half-frame and low for the right. The word's MSB occupies slot 0 of its half, and later bits follow in descending order.
- R4: Framing code 001 (I²S) drives `frameClk` low for the left half-frame and high for the right. Slot 0 of each half is 0, and the MSB sits in slot 1.
- R5: Framing code 010 (right-justified) places the LSB of the output word in slot 31 of its half and drives every slot before the word to 0.
- R6: Resolution code 00/01/10/11 selects 24/20/18/16 output bits. In left-justified and I²S framing, sample bits below the resolution are sent as 0. In right-justified framing the word is the top N sample bits.
- R7: In left-justified and I²S framing, every slot after the last word bit carries 0.
- R8: At a frame start with `sampleValid` high, the pair is taken and `sampleTake` is high for exactly that one cycle, the cycle in which the frame starts. With `sampleValid` low the previous pair is sent again and no pulse is given.
- R9: Ratio, framing and resolution inputs and the sample inputs are used only at frame starts. Changing them mid-frame does not alter the frame being sent.
- R10: During reset `bitClk`=0, `frameClk`=1, `serialOut`=0 and `sampleTake`=0. The first frame starts on the first clock after reset is released, using the inputs present then.
- R11: Framing codes 011..111 behave as code 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the master-clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| ratioSel | input | 4 | Master-clock/frame-clock ratio code |
| fmtSel | input | 3 | Framing code |
| resSel | input | 2 | Output resolution code |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| sampleValid | input | 1 | Sample pair on leftIn/rightIn is valid |
| frameClk | output | 1 | Left/right frame clock |
| bitClk | output | 1 | Bit clock, 64 periods per frame |
| serialOut | output | 1 | Serial audio data |
| sampleTake | output | 1 | One-cycle pulse when a pair is taken |

## Verification
The hardest situation to reach is a change of resolution or samples partway through a frame. It must not reach the right half that is still being sent, but it must apply exactly at the next frame start. The stimulus creates it on purpose. Each time the bench has decoded a complete left half-frame, it draws new samples, a new resolution and a new valid flag, and it checks that the following right half still carries the old settings. Framing and ratio sweeps, including reserved codes and the uneven ratios, run from a fresh reset so that every frame boundary can be located from the frame clock alone.

// File: rtl/asm_pkg.sv
package asm_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 6;              // 64 bit clocks per frame
  localparam int POS_W    = SLOT_W - 1;     // slot within a half-frame
  localparam int RATIO_W  = 4;
  localparam int FMT_W    = 3;
  localparam int RES_W    = 2;
  localparam int CNT_W    = 6;              // holds the longest half period (32)
  localparam int NUM_CH   = 2;
  localparam int IDX_W    = $clog2(SAMPLE_W);

  localparam logic [FMT_W-1:0] FMT_I2S = 3'b001;
  localparam logic [FMT_W-1:0] FMT_RJ  = 3'b010;

  typedef struct packed {
    logic              loadFrame;  // frame starts at this edge
    logic [SLOT_W-1:0] slot;       // current bit slot in the frame
  } seqStrobe_t;

  // bit clock half period in clk cycles = ratio / 32
  function automatic logic [CNT_W-1:0] halfLenOf(input logic [RATIO_W-1:0] code);
    case (code)
      4'd0:    halfLenOf = 6'd2;
      4'd1:    halfLenOf = 6'd3;
      4'd2:    halfLenOf = 6'd4;
      4'd3:    halfLenOf = 6'd6;
      4'd4:    halfLenOf = 6'd8;
      4'd5:    halfLenOf = 6'd12;
      4'd6:    halfLenOf = 6'd16;
      4'd7:    halfLenOf = 6'd24;
      default: halfLenOf = 6'd32;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] resBitsOf(input logic [RES_W-1:0] code);
    case (code)
      2'b00:   resBitsOf = 6'd24;
      2'b01:   resBitsOf = 6'd20;
      2'b10:   resBitsOf = 6'd18;
      default: resBitsOf = 6'd16;
    endcase
  endfunction
endpackage

// File: rtl/asm_clock_seq.sv
module asm_clock_seq
  import asm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioSel,
  output logic               bitClk,
  output seqStrobe_t         seq
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  logic              armed;
  logic [CNT_W-1:0]  halfCnt;
  logic [CNT_W-1:0]  halfLen;
  logic [SLOT_W-1:0] slotQ;
  logic              bitClkQ;
  logic              halfDone;
  logic              frameWrap;

  assign halfDone  = armed && (halfCnt == halfLen - 1'b1);
  assign frameWrap = halfDone && bitClkQ && (slotQ == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      halfCnt <= '0;
      halfLen <= halfLenOf('0);
      slotQ   <= '0;
      bitClkQ <= 1'b0;
    end else if (!armed) begin
      armed   <= 1'b1;
      halfCnt <= '0;
      halfLen <= halfLenOf(ratioSel);
    end else if (halfDone) begin
      halfCnt <= '0;
      bitClkQ <= ~bitClkQ;
      if (bitClkQ) slotQ <= slotQ + 1'b1;
      if (frameWrap) halfLen <= halfLenOf(ratioSel);
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  assign bitClk        = bitClkQ;
  assign seq.loadFrame = !armed || frameWrap;
  assign seq.slot      = slotQ;

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $changed(slotQ) |-> (slotQ == $past(slotQ) + 1'b1)); // R1
  AST_SLOT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $changed(slotQ) |-> $fell(bitClkQ)); // R2
  AST_RATIO_AT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $changed(halfLen) |-> (slotQ == '0 && !bitClkQ)); // R9
endmodule

// File: rtl/asm_serializer.sv
module asm_serializer
  import asm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          seq,
  input  logic [FMT_W-1:0]    fmtSel,
  input  logic [RES_W-1:0]    resSel,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                sampleValid,
  output logic                frameClk,
  output logic                serialOut,
  output logic                sampleTake
);
  logic [SAMPLE_W-1:0] chanIn   [NUM_CH];
  logic [SAMPLE_W-1:0] chanWord [NUM_CH];
  logic [FMT_W-1:0]    fmtQ;
  logic [RES_W-1:0]    resQ;
  logic                takeQ;

  assign chanIn[0] = leftIn;
  assign chanIn[1] = rightIn;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] holdQ;
    always_ff @(posedge clk) begin
      if (!rstN)                           holdQ <= '0;
      else if (seq.loadFrame && sampleValid) holdQ <= chanIn[ch];
    end
    assign chanWord[ch] = holdQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtQ  <= '0;
      resQ  <= '0;
      takeQ <= 1'b0;
    end else begin
      takeQ <= seq.loadFrame && sampleValid;
      if (seq.loadFrame) begin
        fmtQ <= fmtSel;
        resQ <= resSel;
      end
    end
  end

  logic [POS_W-1:0]    pos;
  logic                chanSel;
  logic [SLOT_W-1:0]   resBits;
  logic [SLOT_W-1:0]   dropCnt;
  logic [SLOT_W-1:0]   lead;
  logic [SAMPLE_W-1:0] keepMask;
  logic [SAMPLE_W-1:0] rawWord;
  logic [SAMPLE_W-1:0] trimWord;
  logic [SAMPLE_W-1:0] srcWord;
  logic [IDX_W-1:0]    bitIdx;
  logic                inWord;

  assign pos      = seq.slot[POS_W-1:0];
  assign chanSel  = seq.slot[SLOT_W-1];
  assign resBits  = resBitsOf(resQ);
  assign dropCnt  = SLOT_W'(SAMPLE_W) - resBits;
  assign lead     = 6'd32 - resBits;
  assign keepMask = {SAMPLE_W{1'b1}} << dropCnt;
  assign rawWord  = chanWord[chanSel];
  assign trimWord = rawWord & keepMask;

  always_comb begin
    case (fmtQ)
      FMT_I2S: begin
        inWord  = (pos != '0) && ({1'b0, pos} <= SLOT_W'(SAMPLE_W));
        bitIdx  = IDX_W'(SAMPLE_W) - pos;
        srcWord = trimWord;
      end
      FMT_RJ: begin
        inWord  = ({1'b0, pos} >= lead);
        bitIdx  = IDX_W'(SAMPLE_W - 1) - (pos - lead[POS_W-1:0]);
        srcWord = rawWord;
      end
      default: begin
        inWord  = ({1'b0, pos} < SLOT_W'(SAMPLE_W));
        bitIdx  = IDX_W'(SAMPLE_W - 1) - pos;
        srcWord = trimWord;
      end
    endcase
  end

  assign serialOut  = inWord && srcWord[bitIdx];
  assign frameClk   = (fmtQ == FMT_I2S) ? chanSel : ~chanSel;
  assign sampleTake = takeQ;

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !seq.loadFrame |=> ($stable(chanWord[0]) && $stable(chanWord[1]))); // R8
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    takeQ |=> !takeQ); // R8
  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !seq.loadFrame |=> ($stable(fmtQ) && $stable(resQ))); // R9
endmodule

// File: rtl/audio_serial_master.sv
module audio_serial_master
  import asm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [RATIO_W-1:0]  ratioSel,
  input  logic [FMT_W-1:0]    fmtSel,
  input  logic [RES_W-1:0]    resSel,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                sampleValid,
  output logic                frameClk,
  output logic                bitClk,
  output logic                serialOut,
  output logic                sampleTake
);
  seqStrobe_t seq;

  asm_clock_seq u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .ratioSel (ratioSel),
    .bitClk   (bitClk),
    .seq      (seq)
  );

  asm_serializer u_ser (
    .clk         (clk),
    .rstN        (rstN),
    .seq         (seq),
    .fmtSel      (fmtSel),
    .resSel      (resSel),
    .leftIn      (leftIn),
    .rightIn     (rightIn),
    .sampleValid (sampleValid),
    .frameClk    (frameClk),
    .serialOut   (serialOut),
    .sampleTake  (sampleTake)
  );

  AST_FRAME_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $changed(frameClk) |-> !bitClk); // R2
  AST_DATA_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $changed(serialOut) |-> !bitClk); // R2
endmodule

// File: tb/audio_serial_master_tb_top.sv
module audio_serial_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  ratioSel = '0;
  logic [2:0]  fmtSel = '0;
  logic [1:0]  resSel = '0;
  logic [23:0] leftIn = '0;
  logic [23:0] rightIn = '0;
  logic        sampleValid = 1'b0;
  logic        frameClk, bitClk, serialOut, sampleTake;

  audio_serial_master dut_i (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel), .fmtSel(fmtSel), .resSel(resSel),
    .leftIn(leftIn), .rightIn(rightIn), .sampleValid(sampleValid),
    .frameClk(frameClk), .bitClk(bitClk), .serialOut(serialOut), .sampleTake(sampleTake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int ratioOf(input int code);
    case (code)
      0: return 64;   1: return 96;   2: return 128;  3: return 192;
      4: return 256;  5: return 384;  6: return 512;  7: return 768;
      default: return 1024;
    endcase
  endfunction

  function automatic int resN(input logic [1:0] r);
    case (r)
      2'b00: return 24; 2'b01: return 20; 2'b10: return 18; default: return 16;
    endcase
  endfunction

  function automatic logic leftLevel(input int fmt);
    return (fmt == 1) ? 1'b0 : 1'b1;
  endfunction

  function automatic string fmtTag(input int fmt);
    case (fmt)
      0: return "R3 R6 R7 R9";
      1: return "R4 R6 R7 R9";
      2: return "R5 R6 R9";
      default: return "R11 R6 R7";
    endcase
  endfunction

  // expected 32 slots of one half-frame, first slot in bit 31
  function automatic logic [31:0] expHalf(input logic [23:0] w, input int fmt,
                                          input logic [1:0] res);
    int n;
    logic [23:0] t;
    n = resN(res);
    t = w & ~((24'h1 << (24 - n)) - 24'h1);
    if (fmt == 1) return {1'b0, t, 7'b0};
    if (fmt == 2) return 32'(w >> (24 - n));
    return {t, 8'b0};
  endfunction

  // bench model
  int          curFmt = 0;
  int          curRatio = 0;
  logic [1:0]  curRes = '0, pendRes = '0;
  logic [23:0] curL = '0, curR = '0, pendL = '0, pendR = '0;
  bit          pendValid = 1'b1;
  bit          synced = 1'b0;
  bit          haveRise = 1'b0;
  bit          isLeft;
  logic [31:0] bits = '0;
  logic [31:0] expBits;
  int          nBits = 0;
  int          framesDone = 0;
  int          frameCycles = 0;
  int          riseGap = 0;
  logic        prevF = 1'b1, prevB = 1'b0, prevS = 1'b0;
  event        midEv;

  always @(negedge clk) begin
    if (!rstN) begin
      synced = 1'b0; haveRise = 1'b0; nBits = 0; bits = '0;
      frameCycles = 0; riseGap = 0;
    end else begin
      frameCycles++;
      riseGap++;
      if (synced && (frameClk != prevF || serialOut != prevS))
        check(prevB == 1'b1 && bitClk == 1'b0, "R2", "line changed away from falling bit clock",
              {prevB, bitClk}, 2'b10);
      if (frameClk != prevF) begin
        if (synced) begin
          isLeft  = (prevF == leftLevel(curFmt));
          expBits = expHalf(isLeft ? curL : curR, curFmt, curRes);
          check(nBits == 32, "R1", "bit clocks per half-frame", nBits, 32);
          check(bits == expBits, fmtTag(curFmt), isLeft ? "left half bits" : "right half bits",
                bits, expBits);
          if (isLeft) begin
            -> midEv;
          end else begin
            check(sampleTake == pendValid, "R8", "take pulse at frame start", sampleTake, pendValid);
            check(frameCycles == 4 * ratioOf(curRatio), "R1", "frame length in clk cycles",
                  frameCycles, 4 * ratioOf(curRatio));
            if (pendValid) begin curL = pendL; curR = pendR; end
            curRes = pendRes;
            framesDone++;
          end
        end else if (frameClk == leftLevel(curFmt)) begin
          synced = 1'b1;
          curL = pendL; curR = pendR; curRes = pendRes;
        end
        if (frameClk == leftLevel(curFmt)) frameCycles = 0;
        nBits = 0;
        bits = '0;
      end else if (synced && sampleTake) begin
        check(1'b0, "R8", "take pulse away from frame start", 1, 0);
      end
      if (bitClk && !prevB) begin
        if (synced && haveRise)
          check(riseGap == ratioOf(curRatio) / 16, "R1", "bit clock period",
                riseGap, ratioOf(curRatio) / 16);
        haveRise = synced;
        riseGap = 0;
        bits = {bits[30:0], serialOut};
        nBits++;
      end
    end
    prevF = frameClk; prevB = bitClk; prevS = serialOut;
  end

  int midCount = 0;

  task automatic drawNext();
    logic [23:0] l, r;
    case (midCount)
      0: begin l = 24'hFFFFFF; r = 24'h800000; end
      1: begin l = 24'h000001; r = 24'h7FFFFF; end
      2: begin l = 24'hA5A5A5; r = 24'h5A5A5A; end
      default: begin l = 24'($urandom); r = 24'($urandom); end
    endcase
    midCount++;
    pendValid   = (midCount < 4) ? 1'b1 : (($urandom % 4) != 0);
    pendRes     = 2'($urandom);
    sampleValid = pendValid;
    resSel      = pendRes;
    leftIn      = l;
    rightIn     = r;
    if (pendValid) begin pendL = l; pendR = r; end
  endtask

  task automatic runPhase(input int fmtCode, input int ratioCode, input int frames);
    int startFrames;
    rstN        = 1'b0;
    curFmt      = fmtCode;
    curRatio    = ratioCode;
    fmtSel      = 3'(fmtCode);
    ratioSel    = 4'(ratioCode);
    pendRes     = 2'($urandom);
    pendL       = 24'($urandom);
    pendR       = 24'($urandom);
    pendValid   = 1'b1;
    resSel      = pendRes;
    leftIn      = pendL;
    rightIn     = pendR;
    sampleValid = 1'b1;
    midCount    = 0;
    repeat (3) @(negedge clk);
    check(bitClk == 1'b0, "R10", "bit clock in reset", bitClk, 0);
    check(frameClk == 1'b1, "R10", "frame clock in reset", frameClk, 1);
    check(serialOut == 1'b0, "R10", "data in reset", serialOut, 0);
    check(sampleTake == 1'b0, "R10", "take pulse in reset", sampleTake, 0);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(sampleTake == 1'b1, "R10", "first frame takes pair after reset", sampleTake, 1);
    startFrames = framesDone;
    while (framesDone - startFrames < frames) begin
      @(midEv);
      drawNext();
    end
  endtask

  initial begin
    void'($urandom(32'd8422));
    // framing sweep at the shortest ratio, reserved code included
    runPhase(0, 0, 14);
    runPhase(1, 0, 14);
    runPhase(2, 0, 14);
    runPhase(5, 0, 10);
    // ratio sweep, uneven ratios and reserved ratio codes included
    for (int code = 1; code <= 8; code++) runPhase(code % 3, code, 3);
    runPhase(1, 12, 3);
    runPhase(2, 15, 2);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL R1 watchdog: actual=%0d cycles expected=completion before that", WATCHDOG);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule